// File: doc/BRIEF.md
# Crystal Temperature Compensation Calculator

The block turns a die temperature sample into the frequency error of a tuning-fork crystal, using a parabolic model centred on a programmable turnover temperature. Above the turnover one curvature coefficient applies and below it a second one. The parabola always opens downward, so the block reports an error that is zero or negative. The result is a signed correction in sixteenths of a ppm. A later stage uses it to trim the oscillator.

Software programs four small registers through a write port and reads them back through a read port. The registers hold the turnover code, the hot-side coefficient, the cold-side coefficient and a sense-enable bit. While sense-enable is set, the two coefficient registers are frozen. Temperature samples arrive with a valid strobe. Each sample produces exactly one result strobe a fixed number of cycles later.

Top module: `xtal_comp_calc`

## Requirements
- R1: The 5-bit turnover code has a direction flag in bit 4 and an offset in bits 3:0. Flag 1 means below 25.0 °C and flag 0 means at or above it. The offset counts 0.5 °C steps. T0, in half-degree units, is 50 − offset when the flag is set and 50 + offset otherwise. Codes 00000 and 10000 both give T0 = 50.
- R2: When the clamped temperature is at or above T0, the hot coefficient (address 1) is used. When it is below T0, the cold coefficient (address 2) is used.
- R3: Let d be the clamped temperature minus T0, in half-degree units, and c the selected coefficient. The output is −floor(c·d²/512), in units of 1/16 ppm. This equals −(c/2048)·(ΔT in °C)², with the magnitude truncated.
- R4: The output is 0 when the temperature equals T0. It is never positive.
- R5: The temperature input is a signed count of 0.5 °C. Any sample above 170 (+85 °C) is computed as 170.
- R6: out_valid_o is high for exactly one cycle, in the second cycle after each cycle with valid_i high. It stays low otherwise. Back-to-back samples produce back-to-back results.
- R7: The register map is: address 0 holds the turnover code in bits 4:0, address 1 the hot coefficient in bits 6:0, address 2 the cold coefficient in bits 6:0, and address 3 sense-enable in bit 0. rd_data_o returns, zero-extended, the value currently in effect at rd_addr_i.
- R8: After reset, the registers hold: turnover code 00000, hot coefficient 70, cold coefficient 68, and sense-enable 0.
- R9: While sense-enable is 1, writes to addresses 1 and 2 leave those registers unchanged. Writes to addresses 0 and 3 always take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Temperature sample strobe |
| temp_i | input | 10 | Signed temperature, 0.5 °C per LSB |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data |
| out_valid_o | output | 1 | Result strobe |
| ppm_o | output | 21 | Signed frequency error, 1/16 ppm per LSB |

## Verification
The assertions check several properties on every cycle:
- the two-cycle result timing in both directions;
- that no result is positive;
- a zero result whenever the pipelined offset is zero;
- that the clamped offset never exceeds the hot limit minus the lowest turnover;
- that a locked coefficient holds its value across a write.

Other properties are shown only by the bench's scenarios, against its own model:
- the exact magnitude of the result;
- the choice between the hot and cold coefficient;
- the turnover decoding of both sign encodings;
- the reset contents;
- that writes to the turnover code and control register still take effect while the coefficients are locked.

// File: rtl/xtc_pkg.sv
package xtc_pkg;
  localparam int unsigned TURN_W      = 5;
  localparam int unsigned COEF_W      = 7;
  localparam int unsigned REG_W       = 8;
  localparam int unsigned ADDR_W      = 2;
  localparam int unsigned COEF_LOG2   = 11;  // coefficient scale 2048
  localparam int unsigned FRAC_BITS   = 4;   // 1/16 ppm output
  localparam int          TURN_CENTER = 50;  // 25.0 C in half degrees
  localparam int          TURN_SPAN   = 15;
  localparam int          TURN_MIN    = TURN_CENTER - TURN_SPAN;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_TURN = 2'd0,
    ADDR_HOT  = 2'd1,
    ADDR_COLD = 2'd2,
    ADDR_CTRL = 2'd3
  } xtc_addr_e;

  typedef struct packed {
    logic [TURN_W-1:0] turn;
    logic [COEF_W-1:0] hot;
    logic [COEF_W-1:0] cold;
    logic              sense_en;
  } xtc_cfg_t;
endpackage

// File: rtl/xtc_regs.sv
module xtc_regs
  import xtc_pkg::*;
#(
  parameter logic [TURN_W-1:0] DEF_TURN = '0,
  parameter logic [COEF_W-1:0] DEF_HOT  = 7'd70,
  parameter logic [COEF_W-1:0] DEF_COLD = 7'd68
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  output xtc_cfg_t          cfg_o
);
  xtc_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.turn     <= DEF_TURN;
      cfg_q.hot      <= DEF_HOT;
      cfg_q.cold     <= DEF_COLD;
      cfg_q.sense_en <= 1'b0;
    end else if (wr_en_i) begin
      case (xtc_addr_e'(wr_addr_i))
        ADDR_TURN: cfg_q.turn <= wr_data_i[TURN_W-1:0];
        ADDR_HOT:  if (!cfg_q.sense_en) cfg_q.hot  <= wr_data_i[COEF_W-1:0];
        ADDR_COLD: if (!cfg_q.sense_en) cfg_q.cold <= wr_data_i[COEF_W-1:0];
        default:   cfg_q.sense_en <= wr_data_i[0];
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (xtc_addr_e'(rd_addr_i))
      ADDR_TURN: rd_data_o[TURN_W-1:0] = cfg_q.turn;
      ADDR_HOT:  rd_data_o[COEF_W-1:0] = cfg_q.hot;
      ADDR_COLD: rd_data_o[COEF_W-1:0] = cfg_q.cold;
      default:   rd_data_o[0]          = cfg_q.sense_en;
    endcase
  end

  assign cfg_o = cfg_q;

  AST_HOT_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && cfg_q.sense_en && wr_addr_i == ADDR_HOT) |=> $stable(cfg_q.hot)); // R9
  AST_COLD_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && cfg_q.sense_en && wr_addr_i == ADDR_COLD) |=> $stable(cfg_q.cold)); // R9
endmodule

// File: rtl/xtc_turn_dec.sv
module xtc_turn_dec
  import xtc_pkg::*;
#(
  parameter int unsigned TEMP_W = 10
) (
  input  logic [TURN_W-1:0]        code_i,
  output logic signed [TEMP_W-1:0] t0_o
);
  int step;
  int t0_int;

  always_comb begin
    step   = int'(code_i[TURN_W-2:0]);
    // flag set means below the centre point
    t0_int = code_i[TURN_W-1] ? (TURN_CENTER - step) : (TURN_CENTER + step);
    t0_o   = TEMP_W'(t0_int);
  end
endmodule

// File: rtl/xtc_curve.sv
module xtc_curve
  import xtc_pkg::*;
#(
  parameter int unsigned TEMP_W    = 10,
  parameter int          HOT_LIMIT = 170,
  localparam int unsigned DW     = TEMP_W + 1,
  localparam int unsigned SQ_W   = 2 * DW,
  localparam int unsigned PROD_W = SQ_W + COEF_W,
  localparam int unsigned SHIFT  = COEF_LOG2 + 2 - FRAC_BITS,
  localparam int unsigned RES_W  = PROD_W - SHIFT + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [TEMP_W-1:0] temp_i,
  input  logic signed [TEMP_W-1:0] t0_i,
  input  logic [COEF_W-1:0]        hot_i,
  input  logic [COEF_W-1:0]        cold_i,
  output logic                     valid_o,
  output logic signed [RES_W-1:0]  ppm_o
);
  localparam logic signed [TEMP_W-1:0] LIMIT_S = TEMP_W'(HOT_LIMIT);
  localparam logic signed [DW-1:0]     DMAX_S  = DW'(HOT_LIMIT - TURN_MIN);

  // stage 1: clamp, offset, side select
  logic signed [TEMP_W-1:0] t_clamp;
  logic signed [DW-1:0]     delta_d;
  logic [COEF_W-1:0]        coef_d;

  assign t_clamp = (temp_i > LIMIT_S) ? LIMIT_S : temp_i;
  assign delta_d = $signed({t_clamp[TEMP_W-1], t_clamp}) - $signed({t0_i[TEMP_W-1], t0_i});
  assign coef_d  = delta_d[DW-1] ? cold_i : hot_i;

  logic                 s1_valid;
  logic signed [DW-1:0] s1_delta;
  logic [COEF_W-1:0]    s1_coef;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_delta <= '0;
      s1_coef  <= '0;
    end else begin
      s1_valid <= valid_i;
      if (valid_i) begin
        s1_delta <= delta_d;
        s1_coef  <= coef_d;
      end
    end
  end

  // stage 2: square, scale, negate
  logic [DW-1:0]       abs_d;
  logic [SQ_W-1:0]     sq;
  logic [PROD_W-1:0]   prod;
  logic [RES_W-2:0]    mag;
  logic signed [RES_W-1:0] res;

  assign abs_d = s1_delta[DW-1] ? $unsigned(-s1_delta) : $unsigned(s1_delta);
  assign sq    = SQ_W'(abs_d) * SQ_W'(abs_d);
  assign prod  = PROD_W'(sq) * PROD_W'(s1_coef);
  assign mag   = prod[PROD_W-1:SHIFT];
  assign res   = -$signed({1'b0, mag});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ppm_o   <= '0;
    end else begin
      valid_o <= s1_valid;
      if (s1_valid) ppm_o <= res;
    end
  end

  AST_DELTA_CAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid |-> (s1_delta <= DMAX_S)); // R5
  AST_ZERO_AT_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && s1_delta == '0) |=> (ppm_o == '0)); // R4
  AST_NEVER_POSITIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (ppm_o <= 0)); // R4
endmodule

// File: rtl/xtal_comp_calc.sv
module xtal_comp_calc
  import xtc_pkg::*;
#(
  parameter int unsigned       TEMP_W    = 10,
  parameter int                HOT_LIMIT = 170,
  parameter logic [TURN_W-1:0] DEF_TURN  = '0,
  parameter logic [COEF_W-1:0] DEF_HOT   = 7'd70,
  parameter logic [COEF_W-1:0] DEF_COLD  = 7'd68,
  localparam int unsigned OUT_W = 2 * (TEMP_W + 1) + COEF_W - (COEF_LOG2 + 2 - FRAC_BITS) + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [TEMP_W-1:0] temp_i,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [REG_W-1:0]         wr_data_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [REG_W-1:0]         rd_data_o,
  output logic                     out_valid_o,
  output logic signed [OUT_W-1:0]  ppm_o
);
  xtc_cfg_t                 cfg;
  logic signed [TEMP_W-1:0] t0;

  xtc_regs #(
    .DEF_TURN (DEF_TURN),
    .DEF_HOT  (DEF_HOT),
    .DEF_COLD (DEF_COLD)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .cfg_o     (cfg)
  );

  xtc_turn_dec #(.TEMP_W(TEMP_W)) i_turn_dec (
    .code_i (cfg.turn),
    .t0_o   (t0)
  );

  xtc_curve #(
    .TEMP_W    (TEMP_W),
    .HOT_LIMIT (HOT_LIMIT)
  ) i_curve (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .temp_i  (temp_i),
    .t0_i    (t0),
    .hot_i   (cfg.hot),
    .cold_i  (cfg.cold),
    .valid_o (out_valid_o),
    .ppm_o   (ppm_o)
  );

  AST_RESULT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 out_valid_o); // R6
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 !out_valid_o); // R6
endmodule

// File: tb/test_xtal_comp_calc.sv
`timescale 1ns/1ps
module test_xtal_comp_calc;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               valid = 1'b0;
  logic signed [9:0]  temp = '0;
  logic               wr_en = 1'b0;
  logic [1:0]         wr_addr = '0;
  logic [7:0]         wr_data = '0;
  logic [1:0]         rd_addr = '0;
  logic [7:0]         rd_data;
  logic               out_valid;
  logic signed [20:0] ppm;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int m_turn = 0, m_hot = 70, m_cold = 68, m_en = 0;

  always #2 clk = ~clk;

  xtal_comp_calc i_xtal_comp_calc (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .temp_i(temp),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .out_valid_o(out_valid), .ppm_o(ppm)
  );

  function automatic int t0_of(int code);
    int m = code & 15;
    return ((code & 16) != 0) ? 50 - m : 50 + m;
  endfunction

  function automatic int exp_ppm(int t);
    int tc = (t > 170) ? 170 : t;
    int d = tc - t0_of(m_turn);
    int c = (d >= 0) ? m_hot : m_cold;
    return -((c * d * d) >> 9);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[7:0];
    case (a)
      0: m_turn = d & 31;
      1: if (m_en == 0) m_hot = d & 127;
      2: if (m_en == 0) m_cold = d & 127;
      default: m_en = d & 1;
    endcase
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(int a, int exp, string req);
    @(negedge clk);
    rd_addr = a[1:0];
    #1;
    chk(req, int'(rd_data), exp);
  endtask

  task automatic run(int t, string req);
    int e = exp_ppm(t);
    @(negedge clk);
    valid = 1'b1; temp = t[9:0];
    @(negedge clk);
    valid = 1'b0;
    chk({req, " strobe early"}, int'(out_valid), 0);
    @(negedge clk);
    chk({req, " strobe"}, int'(out_valid), 1);
    chk(req, int'(ppm), e);
    @(negedge clk);
    chk({req, " strobe width"}, int'(out_valid), 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int unsigned sd;
    int codes[5] = '{0, 16, 15, 31, 5};
    int bt[3];
    int be[3];
    sd = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk("R8 strobe idle in reset", int'(out_valid), 0);
    rst_n = 1'b1;

    // R8 reset contents, R7 read map
    rd_chk(0, 0, "R8 turn default");
    rd_chk(1, 70, "R8 hot default");
    rd_chk(2, 68, "R8 cold default");
    rd_chk(3, 0, "R8 enable default");

    // R1 decode: result is zero at decoded T0, nonzero 20 C above
    foreach (codes[i]) begin
      wr(0, codes[i]);
      rd_chk(0, codes[i], "R7 turn readback");
      run(t0_of(codes[i]), "R1 R4 zero at turnover");
      run(t0_of(codes[i]) + 40, "R1 decode offset");
    end

    // R2 side selection
    wr(0, 0); wr(1, 100); wr(2, 50);
    rd_chk(1, 100, "R7 hot readback");
    rd_chk(2, 50, "R7 cold readback");
    run(90, "R2 hot side");
    run(10, "R2 cold side");
    run(51, "R2 just above");
    run(49, "R2 just below");
    run(-512, "R3 coldest input");

    // R5 clamp
    run(170, "R5 at limit");
    run(300, "R5 clamp 300");
    run(511, "R5 clamp max");
    run(171, "R5 clamp 171");

    // R9 lock
    wr(3, 1);
    rd_chk(3, 1, "R7 enable readback");
    wr(1, 11); wr(2, 12);
    rd_chk(1, 100, "R9 hot locked");
    rd_chk(2, 50, "R9 cold locked");
    wr(0, 19);
    rd_chk(0, 19, "R9 turn writable while locked");
    run(120, "R9 locked coefficient in use");
    wr(3, 0);
    wr(1, 41);
    rd_chk(1, 41, "R9 hot writable after unlock");
    run(120, "R9 unlocked coefficient in use");

    // R6 back to back
    bt[0] = 100; bt[1] = -20; bt[2] = 170;
    foreach (bt[i]) be[i] = exp_ppm(bt[i]);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k >= 2 && k < 5) begin
        chk("R6 back to back strobe", int'(out_valid), 1);
        chk("R6 back to back value", int'(ppm), be[k-2]);
      end
      if (k == 5) chk("R6 strobe ends", int'(out_valid), 0);
      if (k < 3) begin valid = 1'b1; temp = bt[k][9:0]; end
      else valid = 1'b0;
    end

    // R3 random
    for (int it = 0; it < 40; it++) begin
      int a = $urandom_range(0, 3);
      wr(a, $urandom_range(0, 255));
      wr($urandom_range(0, 2), $urandom_range(0, 255));
      if ((it % 5) == 0) begin
        rd_chk(1, m_hot, "R7 R9 random hot readback");
        rd_chk(2, m_cold, "R7 R9 random cold readback");
      end
      for (int j = 0; j < 6; j++) begin
        int t = int'($urandom_range(0, 1023)) - 512;
        run(t, "R3 random");
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule